// File: doc/BRIEF.md
# Converter Data-Ready Sequencer

This block is the digital timing core of an oversampling converter. It decides when a fresh conversion result is loaded into the data register and drives the active-low ready line that tells a host processor an unread word is waiting. A plain period counter stands in for the decimation filter. Each time an output period ends, it hands over a word. After any restart, it first lets three output periods of settling pass.

Software-controlled sync and standby bits stop the result stream without touching the register contents. The ready line remembers whether an unread word exists across both kinds of stop. When a new word arrives while the previous one is still unread, ready goes inactive for a fixed blanking interval, so the host sees a fresh edge. A data-register read strobe clears ready. An active-low hardware reset returns everything to defaults and blocks register access.

Top module: `cvt_ready_seq`

## Requirements
- R1: The effective output period is max(period_cfg, 1000) master clocks. While streaming, successive updates are exactly that many cycles apart, and a period_cfg below 1000 (including 0) behaves as 1000.
- R2: Let N be the first rising edge at which sync_bit is 0 after being 1, or the first edge after hw_reset_n returns high. The first update occurs at rising edge N + 3·P − 1, where P is the effective period.
- R3: While sync_bit is 1, no update occurs and data_out is unchanged.
- R4: sync_bit never changes rdy_n. If rdy_n is low when sync is applied and released, it stays low until the next update, and that update starts a blanking interval.
- R5: An update that occurs while rdy_n is low drives rdy_n high for exactly 500 cycles. rdy_n then returns low.
- R6: A read strobe with no simultaneous update drives rdy_n high on the next edge. rdy_n stays high until the next update, and that update drives rdy_n low at once. A read strobe during blanking ends the blanking, so ready stays high.
- R7: If a read strobe and an update fall on the same edge, the update wins. The new word is loaded, and if rdy_n was low, the 500-cycle blanking interval runs in full.
- R8: While hw_reset_n is low: rdy_n is 1, acc_block is 1, data_out is 0, upd_pulse is 0, and read strobes have no effect. acc_block falls on the first edge with hw_reset_n high.
- R9: While stby_bit is 1, no update occurs, data_out is kept and rdy_n is unchanged. A read during standby still drives rdy_n high.
- R10: After stby_bit is cleared, the first new word follows the same 3-period timing as R2.
- R11: Each update shows as a one-cycle upd_pulse. data_out advances by exactly 1 per update, starting at 1 after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| hw_reset_n | input | 1 | Active-low hardware reset, sampled synchronously |
| sync_bit | input | 1 | Filter sync bit; 1 holds the filter model in reset |
| stby_bit | input | 1 | Standby bit; 1 halts result production |
| period_cfg | input | PERIOD_W (16) | Requested output period in master clocks |
| rd_strobe | input | 1 | One-cycle data-register read strobe |
| rdy_n | output | 1 | Active-low data-ready line |
| upd_pulse | output | 1 | One-cycle pulse on each data-register update |
| data_out | output | DATA_W (16) | Data register contents (word sequence number) |
| acc_block | output | 1 | High while register access is blocked by reset |

## Verification
The bench measures the exact edge of the first word after each kind of restart (reset, sync, standby). A design that counted two periods, or started counting one edge late, would miss by a full period or by one cycle. It counts the blanking width cycle by cycle, which catches an off-by-one high interval. It also places a read on the very edge of an update: a design where the read won would show ready staying high with no blanking edge. Sync and standby are each applied with ready both low and high, because a design that cleared ready on sync would lose the pending word. A sweep of requested periods around and below the 1000-cycle floor checks the clamp and the spacing.

// File: rtl/cvt_pkg.sv
package cvt_pkg;

    // Ready-line controller state
    typedef enum logic [1:0] {
        R_EMPTY = 2'd0,   // no unread word, ready inactive
        R_BLANK = 2'd1,   // new word replaced unread one, ready held inactive
        R_FULL  = 2'd2    // unread word present, ready active
    } rdy_state_e;

    // Events presented to the ready controller each cycle
    typedef struct packed {
        logic load;   // data register is updated on this edge
        logic read;   // host reads the data register on this edge
    } rdy_evt_t;

    // True when a zero-based count sits on the last cycle of a length
    function automatic logic is_last(input int unsigned cnt, input int unsigned len);
        return (cnt + 1) >= len;
    endfunction

    // Effective period with a floor applied
    function automatic int unsigned floor_period(input int unsigned req, input int unsigned minp);
        return (req < minp) ? minp : req;
    endfunction

endpackage

// File: rtl/cvt_period_timer.sv
module cvt_period_timer
    import cvt_pkg::*;
#(
    parameter int PERIOD_W   = 16,
    parameter int MIN_PERIOD = 1000,
    parameter int SETTLE_N   = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hold,
    input  logic [PERIOD_W-1:0] period_cfg,
    output logic                load_o
);
    localparam int MIN_W = $clog2(MIN_PERIOD + 1);
    localparam int CNT_W = (PERIOD_W > MIN_W) ? PERIOD_W : MIN_W;
    localparam int SET_W = (SETTLE_N > 1) ? $clog2(SETTLE_N) : 1;

    logic [CNT_W-1:0] pcnt;
    logic [SET_W-1:0] scnt;
    logic             period_end;
    logic             settled;
    int unsigned      eff_len;

    always_comb begin
        eff_len    = floor_period(int'(period_cfg), MIN_PERIOD);
        period_end = is_last(int'(pcnt), eff_len);
        settled    = (int'(scnt) == SETTLE_N - 1);
        load_o     = !hold && period_end && settled;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            pcnt <= '0;
            scnt <= '0;
        end else if (period_end) begin
            pcnt <= '0;
            if (!settled) scnt <= scnt + 1'b1;
        end else begin
            pcnt <= pcnt + 1'b1;
        end
    end

endmodule

// File: rtl/cvt_ready_ctrl.sv
module cvt_ready_ctrl
    import cvt_pkg::*;
#(
    parameter int BLANK_CYC = 500
) (
    input  logic     clk,
    input  logic     rst_n,
    input  rdy_evt_t evt,
    output logic     rdy_n_o
);
    localparam int BW = $clog2(BLANK_CYC);

    rdy_state_e    state;
    logic [BW-1:0] bcnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= R_EMPTY;
            bcnt  <= '0;
        end else if (evt.load) begin
            bcnt  <= '0;
            state <= (state == R_EMPTY) ? R_FULL : R_BLANK;
        end else if (evt.read) begin
            state <= R_EMPTY;
            bcnt  <= '0;
        end else if (state == R_BLANK) begin
            if (bcnt == BW'(BLANK_CYC - 1)) begin
                state <= R_FULL;
                bcnt  <= '0;
            end else begin
                bcnt <= bcnt + 1'b1;
            end
        end
    end

    assign rdy_n_o = (state != R_FULL);

    assert_blank_on_update_R5: assert property (@(posedge clk) disable iff (!rst_n)
        evt.load && state == R_FULL |=> rdy_n_o && state == R_BLANK);

    assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        evt.read && !evt.load |=> rdy_n_o);

    assert_update_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        evt.load && evt.read && !rdy_n_o |=> state == R_BLANK);

endmodule

// File: rtl/cvt_data_reg.sv
module cvt_data_reg #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    output logic [DATA_W-1:0] data_o,
    output logic              upd_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_o <= '0;
            upd_o  <= 1'b0;
        end else begin
            upd_o <= load;
            if (load) data_o <= data_o + 1'b1;
        end
    end

    assert_single_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o |=> !upd_o);

endmodule

// File: rtl/cvt_ready_seq.sv
module cvt_ready_seq
    import cvt_pkg::*;
#(
    parameter int PERIOD_W   = 16,
    parameter int DATA_W     = 16,
    parameter int MIN_PERIOD = 1000,
    parameter int BLANK_CYC  = 500,
    parameter int SETTLE_N   = 3
) (
    input  logic                clk,
    input  logic                hw_reset_n,
    input  logic                sync_bit,
    input  logic                stby_bit,
    input  logic [PERIOD_W-1:0] period_cfg,
    input  logic                rd_strobe,
    output logic                rdy_n,
    output logic                upd_pulse,
    output logic [DATA_W-1:0]   data_out,
    output logic                acc_block
);
    logic     hold;
    logic     load;
    rdy_evt_t evt;

    assign hold     = sync_bit || stby_bit;
    assign evt.load = load;
    assign evt.read = rd_strobe;

    cvt_period_timer #(
        .PERIOD_W  (PERIOD_W),
        .MIN_PERIOD(MIN_PERIOD),
        .SETTLE_N  (SETTLE_N)
    ) u_timer (
        .clk       (clk),
        .rst_n     (hw_reset_n),
        .hold      (hold),
        .period_cfg(period_cfg),
        .load_o    (load)
    );

    cvt_ready_ctrl #(
        .BLANK_CYC(BLANK_CYC)
    ) u_ready (
        .clk    (clk),
        .rst_n  (hw_reset_n),
        .evt    (evt),
        .rdy_n_o(rdy_n)
    );

    cvt_data_reg #(
        .DATA_W(DATA_W)
    ) u_data (
        .clk   (clk),
        .rst_n (hw_reset_n),
        .load  (load),
        .data_o(data_out),
        .upd_o (upd_pulse)
    );

    always_ff @(posedge clk) begin
        acc_block <= !hw_reset_n;
    end

    assert_reset_defaults_R8: assert property (@(posedge clk)
        !hw_reset_n |=> rdy_n && acc_block && data_out == '0 && !upd_pulse);

    assert_sync_keeps_ready_R4: assert property (@(posedge clk) disable iff (!hw_reset_n)
        sync_bit && !rd_strobe && !rdy_n |=> !rdy_n);

    assert_sync_freezes_word_R3: assert property (@(posedge clk) disable iff (!hw_reset_n)
        sync_bit |=> $stable(data_out));

    assert_standby_keeps_word_R9: assert property (@(posedge clk) disable iff (!hw_reset_n)
        stby_bit |=> $stable(data_out) && !upd_pulse);

endmodule

// File: tb/sim_cvt_ready_seq.sv
module sim_cvt_ready_seq;
    logic        clk = 1'b0;
    logic        hw_reset_n;
    logic        sync_bit;
    logic        stby_bit;
    logic [15:0] period_cfg;
    logic        rd_strobe;
    logic        rdy_n;
    logic        upd_pulse;
    logic [15:0] data_out;
    logic        acc_block;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    int exp_data = 0;
    int last_c = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    cvt_ready_seq u0 (
        .clk(clk), .hw_reset_n(hw_reset_n), .sync_bit(sync_bit), .stby_bit(stby_bit),
        .period_cfg(period_cfg), .rd_strobe(rd_strobe), .rdy_n(rdy_n),
        .upd_pulse(upd_pulse), .data_out(data_out), .acc_block(acc_block)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_upd(output int c);
        bit seen = 1'b0;
        for (int k = 0; k < 8000; k++) begin
            @(negedge clk);
            if (upd_pulse) begin
                seen = 1'b1;
                break;
            end
        end
        c = cyc;
        if (!seen) chk(1'b0, "R2", "update never arrived", 0, 1);
    endtask

    // rdy_n is high at the current negedge; count cycles it stays high
    task automatic count_high(input string req);
        int n = 1;
        bit pulse_ok = 1'b1;
        for (int k = 0; k < 2000; k++) begin
            @(negedge clk);
            if (k == 0 && upd_pulse) pulse_ok = 1'b0;
            if (rdy_n) n++;
            else break;
        end
        chk(pulse_ok, "R11", "upd_pulse wider than one cycle", 1, 0);
        chk(n == 500, req, "blanking width", n, 500);
    endtask

    task automatic read_pulse();
        @(negedge clk) rd_strobe = 1'b1;
        @(negedge clk) rd_strobe = 1'b0;
    endtask

    task automatic check_word(input string req);
        exp_data++;
        chk(int'(data_out) == exp_data, req, "data_out", int'(data_out), exp_data);
    endtask

    initial begin
        wait (cyc > 150000);
        chk(1'b0, "R2", "watchdog expired", cyc, 150000);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int c0;
        int c;
        int p;
        bit ok;
        int cfgs[6] = '{0, 999, 1000, 1001, 1237, 1500};
        hw_reset_n = 1'b0; sync_bit = 1'b0; stby_bit = 1'b0;
        period_cfg = 16'd1000; rd_strobe = 1'b0;
        repeat (4) @(negedge clk);
        read_pulse();
        @(negedge clk);
        chk(rdy_n == 1'b1, "R8", "rdy_n in reset", rdy_n, 1);
        chk(acc_block == 1'b1, "R8", "acc_block in reset", acc_block, 1);
        chk(data_out == 16'd0, "R8", "data_out in reset", data_out, 0);
        chk(upd_pulse == 1'b0, "R8", "upd_pulse in reset", upd_pulse, 0);

        // reset release -> first word after three periods
        hw_reset_n = 1'b1;
        c0 = cyc;
        @(negedge clk);
        chk(acc_block == 1'b0, "R8", "acc_block after release", acc_block, 0);
        wait_upd(c);
        chk(c == c0 + 3000, "R2", "first word after reset", c - c0, 3000);
        chk(rdy_n == 1'b0, "R6", "ready on word into empty register", rdy_n, 0);
        check_word("R11");
        last_c = c;

        // unread word replaced -> blanking
        wait_upd(c);
        chk(c == last_c + 1000, "R1", "update spacing", c - last_c, 1000);
        chk(rdy_n == 1'b1, "R5", "blanking start", rdy_n, 1);
        check_word("R11");
        last_c = c;
        count_high("R5");

        // read clears ready until the next word
        read_pulse();
        chk(rdy_n == 1'b1, "R6", "ready after read", rdy_n, 1);
        wait_upd(c);
        chk(c == last_c + 1000, "R1", "update spacing", c - last_c, 1000);
        chk(rdy_n == 1'b0, "R6", "ready after word following read", rdy_n, 0);
        check_word("R6");
        last_c = c;

        // read on the very edge of an update
        while (cyc != last_c + 999) @(negedge clk);
        rd_strobe = 1'b1;
        @(negedge clk) rd_strobe = 1'b0;
        chk(upd_pulse == 1'b1, "R7", "update with coincident read", upd_pulse, 1);
        chk(rdy_n == 1'b1, "R7", "blanking with coincident read", rdy_n, 1);
        check_word("R7");
        count_high("R7");

        // sync with ready low
        @(negedge clk) sync_bit = 1'b1;
        ok = 1'b1;
        for (int k = 0; k < 1500; k++) begin
            @(negedge clk);
            if (rdy_n || upd_pulse) ok = 1'b0;
        end
        chk(ok, "R4", "ready low held through sync", ok, 1);
        chk(int'(data_out) == exp_data, "R3", "data frozen in sync", int'(data_out), exp_data);
        sync_bit = 1'b0;
        c0 = cyc;
        wait_upd(c);
        chk(c == c0 + 3000, "R2", "first word after sync", c - c0, 3000);
        chk(rdy_n == 1'b1, "R4", "blanking on first word after sync", rdy_n, 1);
        check_word("R4");
        count_high("R4");

        // sync with ready high
        read_pulse();
        sync_bit = 1'b1;
        repeat (100) @(negedge clk);
        chk(rdy_n == 1'b1, "R4", "ready high held through sync", rdy_n, 1);
        sync_bit = 1'b0;
        c0 = cyc;
        wait_upd(c);
        chk(c == c0 + 3000, "R2", "word after sync, ready high", c - c0, 3000);
        chk(rdy_n == 1'b0, "R4", "ready after sync word", rdy_n, 0);
        check_word("R3");

        // standby
        @(negedge clk) stby_bit = 1'b1;
        ok = 1'b1;
        for (int k = 0; k < 2500; k++) begin
            @(negedge clk);
            if (rdy_n || upd_pulse) ok = 1'b0;
        end
        chk(ok, "R9", "no update and ready kept in standby", ok, 1);
        read_pulse();
        chk(rdy_n == 1'b1, "R9", "read during standby", rdy_n, 1);
        chk(int'(data_out) == exp_data, "R9", "data kept in standby", int'(data_out), exp_data);
        stby_bit = 1'b0;
        c0 = cyc;
        wait_upd(c);
        chk(c == c0 + 3000, "R10", "first word after standby", c - c0, 3000);
        chk(rdy_n == 1'b0, "R10", "ready after standby word", rdy_n, 0);
        check_word("R10");

        // period sweep around the floor
        foreach (cfgs[i]) begin
            p = (cfgs[i] < 1000) ? 1000 : cfgs[i];
            @(negedge clk) sync_bit = 1'b1;
            period_cfg = 16'(cfgs[i]);
            repeat (3) @(negedge clk);
            read_pulse();
            sync_bit = 1'b0;
            c0 = cyc;
            wait_upd(c);
            chk(c == c0 + 3 * p, "R1", "settling of three periods", c - c0, 3 * p);
            chk(rdy_n == 1'b0, "R6", "ready on sweep first word", rdy_n, 0);
            check_word("R11");
            last_c = c;
            wait_upd(c);
            chk(c == last_c + p, "R1", "streaming spacing", c - last_c, p);
            chk(rdy_n == 1'b1, "R5", "sweep blanking start", rdy_n, 1);
            check_word("R11");
            count_high("R5");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule